// File: doc/BRIEF.md
# Message Context Allocation Manager

This block looks after the task contexts of a small message-driven processing node. Local memory is split into equal slots of 16 words each, and every incoming message gets one slot. When the network interface wants to store a new message, the manager gives it the lowest-numbered free slot in the same cycle. The interface then takes the local memory bus and writes the message words into that slot. When the write is finished, the interface commits the slot, and the slot joins the tail of the ready queue.

The execution unit takes ready tasks from the head of that queue. A task can be parked as suspended, and a later resume event that names its slot puts it back on the ready queue. When a task finishes, its slot is released back to the pool. Releasing a slot that is already free is reported as an error and changes nothing.

The same block also arbitrates the local memory bus between the network interface and the context-cache controller. It forms the word address from the owner's slot number and word offset.

Top module: `ctx_alloc_mgr`

## Requirements
- R1: After reset all 256 contexts are free, neither bus master holds a grant, `disp_valid` is low, `rel_err` is low and `mem_addr` is 0.
- R2: `alloc_gnt` is high in the same cycle as `alloc_req` whenever a context is free. `alloc_ctx` then shows the lowest-numbered free context, and that context is no longer offered from the next cycle on.
- R3: When no context is free, `alloc_gnt` stays low while `alloc_req` is held. This stalls the interface until a release frees a context, which is offered in the cycle after the release.
- R4: A commit appends `commit_ctx` to the tail of the ready queue. `disp_valid`/`disp_ctx` show the queue head from the next cycle. The head is removed on a cycle with `disp_valid` and `disp_ready` both high, and entries leave in the order they arrived.
- R5: When a commit and a successful resume happen in the same cycle, the committed context enters the ready queue ahead of the resumed one.
- R6: `susp_valid` marks `susp_ctx` as suspended. A resume naming a suspended context clears the mark and appends the context to the ready queue. A resume naming a context that is not suspended leaves the queue unchanged.
- R7: A release of a busy context makes it free again and clears its suspended mark. A release of a free context raises `rel_err` for exactly one cycle, in the cycle after the release, and leaves the pool unchanged.
- R8: A bus grant appears one cycle after the request and is held for as long as the owner keeps requesting. At most one master holds the grant.
- R9: When both masters request and the bus is not held, the master that did not win the last grant wins. The first contention after reset goes to the network interface.
- R10: While a master holds the bus, `mem_addr` is its context number times 16 plus its word offset (12 bits). With no owner, `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Interface asks for a context |
| alloc_gnt | output | 1 | Context granted this cycle |
| alloc_ctx | output | 8 | Granted context number |
| commit_valid | input | 1 | Message fully written, make task ready |
| commit_ctx | input | 8 | Context being committed |
| disp_ready | input | 1 | Execution unit takes the head task |
| disp_valid | output | 1 | Ready queue not empty |
| disp_ctx | output | 8 | Context at the ready queue head |
| susp_valid | input | 1 | Suspend a task |
| susp_ctx | input | 8 | Context being suspended |
| resume_valid | input | 1 | Resume event |
| resume_ctx | input | 8 | Context named by the resume event |
| rel_valid | input | 1 | Task completed, free its context |
| rel_ctx | input | 8 | Context being released |
| rel_err | output | 1 | Previous release named a free context |
| ni_bus_req | input | 1 | Network interface requests the memory bus |
| ni_ctx | input | 8 | Interface context for the address |
| ni_off | input | 4 | Interface word offset |
| cc_bus_req | input | 1 | Cache controller requests the memory bus |
| cc_ctx | input | 8 | Cache controller context for the address |
| cc_off | input | 4 | Cache controller word offset |
| ni_bus_gnt | output | 1 | Bus owned by network interface |
| cc_bus_gnt | output | 1 | Bus owned by cache controller |
| mem_addr | output | 12 | Local memory word address |

## Verification
The bench fills the pool completely. A pool that wrapped its allocation pointer or ignored exhaustion would then grant a context that is still in use. It releases the same context twice: a free list without a per-slot busy record would accept the second release and hand the slot out twice. It fires a commit and a resume in the same cycle, which catches a queue that drops one of two pushes or swaps their order. It also resumes a context that was never suspended, where a design that skips the suspended check would dispatch a phantom task. It drives simultaneous bus requests, where a fixed-priority arbiter would starve the controller, and it drops a request in the middle of a hold, where an arbiter that ignores release would keep a stale grant on the address mux.

// File: rtl/ctx_pkg.sv
`timescale 1ns/1ps
package ctx_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_NI   = 2'd1,
        OWN_CC   = 2'd2
    } bus_owner_e;
endpackage

// File: rtl/ctx_free_pool.sv
`timescale 1ns/1ps
module ctx_free_pool #(
    parameter int NCTX = 256,
    parameter int IDW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take,
    input  logic           rel_valid,
    input  logic [IDW-1:0] rel_ctx,
    output logic           avail,
    output logic [IDW-1:0] pick,
    output logic           rel_err
);
    typedef struct packed {
        logic [NCTX-1:0] busy;
        logic            err;
    } pool_t;

    pool_t st_d, st_q;

    always_comb begin
        pick = '0;
        for (int i = NCTX - 1; i >= 0; i--) begin
            if (!st_q.busy[i]) pick = IDW'(i);
        end
        avail = ~&st_q.busy;

        st_d     = st_q;
        st_d.err = 1'b0;
        if (take) st_d.busy[pick] = 1'b1;
        if (rel_valid) begin
            if (st_q.busy[rel_ctx]) st_d.busy[rel_ctx] = 1'b0;
            else                    st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rel_err = st_q.err;

    // R2
    alloc_nodup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (pick != $past(pick)) || !avail);

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> $past(rel_valid));
endmodule

// File: rtl/ctx_task_sched.sv
`timescale 1ns/1ps
module ctx_task_sched #(
    parameter int NCTX = 256,
    parameter int IDW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           commit_valid,
    input  logic [IDW-1:0] commit_ctx,
    input  logic           susp_valid,
    input  logic [IDW-1:0] susp_ctx,
    input  logic           resume_valid,
    input  logic [IDW-1:0] resume_ctx,
    input  logic           rel_valid,
    input  logic [IDW-1:0] rel_ctx,
    input  logic           disp_ready,
    output logic           disp_valid,
    output logic [IDW-1:0] disp_ctx
);
    typedef struct {
        logic [IDW-1:0]  slot [NCTX];
        logic [IDW-1:0]  rptr;
        logic [IDW-1:0]  wptr;
        logic [IDW:0]    cnt;
        logic [NCTX-1:0] susp;
    } sched_t;

    sched_t st_d, st_q;
    logic   resume_hit;
    logic   pop;

    always_comb begin
        logic [1:0] n;
        resume_hit = resume_valid && st_q.susp[resume_ctx];
        pop        = disp_ready && (st_q.cnt != '0);
        st_d       = st_q;
        n          = 2'd0;
        if (commit_valid) begin
            st_d.slot[st_q.wptr] = commit_ctx;
            n = 2'd1;
        end
        if (resume_hit) begin
            st_d.slot[st_q.wptr + IDW'(n)] = resume_ctx;
            n = n + 2'd1;
        end
        st_d.wptr = st_q.wptr + IDW'(n);
        st_d.rptr = st_q.rptr + IDW'(pop);
        st_d.cnt  = st_q.cnt + {{(IDW-1){1'b0}}, n} - {{IDW{1'b0}}, pop};
        if (susp_valid) st_d.susp[susp_ctx]   = 1'b1;
        if (resume_hit) st_d.susp[resume_ctx] = 1'b0;
        if (rel_valid)  st_d.susp[rel_ctx]    = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rptr <= '0;
            st_q.wptr <= '0;
            st_q.cnt  <= '0;
            st_q.susp <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign disp_valid = (st_q.cnt != '0);
    assign disp_ctx   = st_q.slot[st_q.rptr];

    // R4
    head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_ctx));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= (IDW+1)'(NCTX));
endmodule

// File: rtl/ctx_bus_arb.sv
`timescale 1ns/1ps
module ctx_bus_arb
    import ctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ni_req,
    input  logic cc_req,
    output logic ni_gnt,
    output logic cc_gnt
);
    typedef struct packed {
        bus_owner_e owner;
        bus_owner_e last;
    } arb_t;

    arb_t st_d, st_q;

    always_comb begin
        logic keep;
        st_d = st_q;
        keep = (st_q.owner == OWN_NI && ni_req) || (st_q.owner == OWN_CC && cc_req);
        if (!keep) begin
            if (ni_req && cc_req) st_d.owner = (st_q.last == OWN_NI) ? OWN_CC : OWN_NI;
            else if (ni_req)      st_d.owner = OWN_NI;
            else if (cc_req)      st_d.owner = OWN_CC;
            else                  st_d.owner = OWN_NONE;
        end
        if (st_d.owner != OWN_NONE) st_d.last = st_d.owner;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.owner <= OWN_NONE;
            st_q.last  <= OWN_CC;
        end else begin
            st_q <= st_d;
        end
    end

    assign ni_gnt = (st_q.owner == OWN_NI);
    assign cc_gnt = (st_q.owner == OWN_CC);

    // R8
    ni_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ni_gnt && ni_req |=> ni_gnt);

    // R8
    cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_gnt && cc_req |=> cc_gnt);

    // R8
    grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ni_gnt) |-> $past(ni_req));
endmodule

// File: rtl/ctx_alloc_mgr.sv
`timescale 1ns/1ps
module ctx_alloc_mgr #(
    parameter int   NCTX      = 256,
    parameter int   CTX_WORDS = 16,
    localparam int  IDW       = $clog2(NCTX),
    localparam int  OFFW      = $clog2(CTX_WORDS),
    localparam int  AW        = IDW + OFFW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_req,
    output logic            alloc_gnt,
    output logic [IDW-1:0]  alloc_ctx,
    input  logic            commit_valid,
    input  logic [IDW-1:0]  commit_ctx,
    input  logic            disp_ready,
    output logic            disp_valid,
    output logic [IDW-1:0]  disp_ctx,
    input  logic            susp_valid,
    input  logic [IDW-1:0]  susp_ctx,
    input  logic            resume_valid,
    input  logic [IDW-1:0]  resume_ctx,
    input  logic            rel_valid,
    input  logic [IDW-1:0]  rel_ctx,
    output logic            rel_err,
    input  logic            ni_bus_req,
    input  logic [IDW-1:0]  ni_ctx,
    input  logic [OFFW-1:0] ni_off,
    input  logic            cc_bus_req,
    input  logic [IDW-1:0]  cc_ctx,
    input  logic [OFFW-1:0] cc_off,
    output logic            ni_bus_gnt,
    output logic            cc_bus_gnt,
    output logic [AW-1:0]   mem_addr
);
    logic pool_avail;

    assign alloc_gnt = alloc_req && pool_avail;

    ctx_free_pool #(.NCTX(NCTX), .IDW(IDW)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (alloc_gnt),
        .rel_valid (rel_valid),
        .rel_ctx   (rel_ctx),
        .avail     (pool_avail),
        .pick      (alloc_ctx),
        .rel_err   (rel_err)
    );

    ctx_task_sched #(.NCTX(NCTX), .IDW(IDW)) u_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_valid (commit_valid),
        .commit_ctx   (commit_ctx),
        .susp_valid   (susp_valid),
        .susp_ctx     (susp_ctx),
        .resume_valid (resume_valid),
        .resume_ctx   (resume_ctx),
        .rel_valid    (rel_valid),
        .rel_ctx      (rel_ctx),
        .disp_ready   (disp_ready),
        .disp_valid   (disp_valid),
        .disp_ctx     (disp_ctx)
    );

    ctx_bus_arb u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .ni_req (ni_bus_req),
        .cc_req (cc_bus_req),
        .ni_gnt (ni_bus_gnt),
        .cc_gnt (cc_bus_gnt)
    );

    always_comb begin
        if (ni_bus_gnt)      mem_addr = AW'(ni_ctx) * AW'(CTX_WORDS) + AW'(ni_off);
        else if (cc_bus_gnt) mem_addr = AW'(cc_ctx) * AW'(CTX_WORDS) + AW'(cc_off);
        else                 mem_addr = '0;
    end
endmodule

// File: tb/ctx_alloc_mgr_bench.sv
`timescale 1ns/1ps
module ctx_alloc_mgr_bench;
    localparam int NCTX = 256;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       alloc_req, commit_valid, disp_ready, susp_valid, resume_valid, rel_valid;
    logic [7:0] commit_ctx, susp_ctx, resume_ctx, rel_ctx, ni_ctx, cc_ctx;
    logic [3:0] ni_off, cc_off;
    logic       ni_bus_req, cc_bus_req;
    logic       alloc_gnt, disp_valid, rel_err, ni_bus_gnt, cc_bus_gnt;
    logic [7:0] alloc_ctx, disp_ctx;
    logic [11:0] mem_addr;

    always #2.5 clk = ~clk;

    ctx_alloc_mgr u_ctx_alloc_mgr (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_ctx(alloc_ctx),
        .commit_valid(commit_valid), .commit_ctx(commit_ctx),
        .disp_ready(disp_ready), .disp_valid(disp_valid), .disp_ctx(disp_ctx),
        .susp_valid(susp_valid), .susp_ctx(susp_ctx),
        .resume_valid(resume_valid), .resume_ctx(resume_ctx),
        .rel_valid(rel_valid), .rel_ctx(rel_ctx), .rel_err(rel_err),
        .ni_bus_req(ni_bus_req), .ni_ctx(ni_ctx), .ni_off(ni_off),
        .cc_bus_req(cc_bus_req), .cc_ctx(cc_ctx), .cc_off(cc_off),
        .ni_bus_gnt(ni_bus_gnt), .cc_bus_gnt(cc_bus_gnt), .mem_addr(mem_addr)
    );

    // behavioural reference state
    bit    busy_m [NCTX];
    bit    susp_m [NCTX];
    int    rq [$];
    int    own_m;   // 0 none, 1 interface, 2 cache controller
    int    last_m;
    bit    err_m;
    int    nvec, nfail;
    string phase;
    bit    done;

    task automatic chk(input int act, input int exp, input string tag);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < NCTX; i++) if (!busy_m[i]) return i;
        return -1;
    endfunction

    task automatic idle();
        alloc_req = 0; commit_valid = 0; disp_ready = 0; susp_valid = 0;
        resume_valid = 0; rel_valid = 0; ni_bus_req = 0; cc_bus_req = 0;
        commit_ctx = 0; susp_ctx = 0; resume_ctx = 0; rel_ctx = 0;
        ni_ctx = 0; cc_ctx = 0; ni_off = 0; cc_off = 0;
    endtask

    // compare outputs against the model, then advance the model one clock
    task automatic tick();
        int  lo, eaddr;
        bit  egnt, edv, rh, was_busy, keep;
        #1;
        lo   = lowest_free();
        egnt = alloc_req && (lo >= 0);
        chk(alloc_gnt, egnt, (lo < 0) ? "R3" : "R2");
        if (egnt) chk(alloc_ctx, lo, "R2");
        edv = (rq.size() > 0);
        chk(disp_valid, edv, "R4");
        if (edv) chk(disp_ctx, rq[0], "R4");
        chk(ni_bus_gnt, own_m == 1, "R8");
        chk(cc_bus_gnt, own_m == 2, "R8");
        eaddr = (own_m == 1) ? ni_ctx * 16 + ni_off : (own_m == 2) ? cc_ctx * 16 + cc_off : 0;
        chk(mem_addr, eaddr, "R10");
        chk(rel_err, err_m, "R7");

        rh       = resume_valid && susp_m[resume_ctx];
        was_busy = busy_m[rel_ctx];
        if (edv && disp_ready) void'(rq.pop_front());
        if (commit_valid) rq.push_back(commit_ctx);
        if (rh) rq.push_back(resume_ctx);
        if (susp_valid) susp_m[susp_ctx] = 1;
        if (rh) susp_m[resume_ctx] = 0;
        if (rel_valid) susp_m[rel_ctx] = 0;
        err_m = rel_valid && !was_busy;
        if (rel_valid && was_busy) busy_m[rel_ctx] = 0;
        if (egnt) busy_m[lo] = 1;
        keep = (own_m == 1 && ni_bus_req) || (own_m == 2 && cc_bus_req);
        if (!keep) begin
            if (ni_bus_req && cc_bus_req) own_m = (last_m == 1) ? 2 : 1;
            else if (ni_bus_req) own_m = 1;
            else if (cc_bus_req) own_m = 2;
            else own_m = 0;
            if (own_m != 0) last_m = own_m;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        nvec = 0; nfail = 0; done = 0; phase = "reset";
        idle();
        rst_n = 0;
        for (int i = 0; i < NCTX; i++) begin busy_m[i] = 0; susp_m[i] = 0; end
        own_m = 0; last_m = 2; err_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        phase = "R1";
        tick();
        tick();

        // R2: three grants, lowest first
        phase = "R2";
        alloc_req = 1;
        repeat (3) tick();
        alloc_req = 0;
        tick();

        // R4: commit 2, 0, 1 then drain in that order
        phase = "R4";
        commit_valid = 1;
        commit_ctx = 2; tick();
        commit_ctx = 0; tick();
        commit_ctx = 1; tick();
        commit_valid = 0;
        tick();
        disp_ready = 1;
        repeat (4) tick();
        disp_ready = 0;

        // R5: commit and resume in one cycle, commit goes first
        phase = "R5";
        susp_valid = 1; susp_ctx = 2; tick();
        susp_valid = 0;
        commit_valid = 1; commit_ctx = 1; resume_valid = 1; resume_ctx = 2; tick();
        commit_valid = 0; resume_valid = 0;
        tick();
        disp_ready = 1; repeat (3) tick(); disp_ready = 0;

        // R6: resume of a context that is not suspended is ignored
        phase = "R6";
        resume_valid = 1; resume_ctx = 9; tick();
        resume_valid = 0; tick(); tick();
        susp_valid = 1; susp_ctx = 9; tick();
        susp_valid = 0;
        resume_valid = 1; resume_ctx = 9; tick();
        resume_valid = 0; tick();
        disp_ready = 1; repeat (2) tick(); disp_ready = 0;

        // R7: release, double release, reuse
        phase = "R7";
        rel_valid = 1; rel_ctx = 1; tick();
        rel_ctx = 1; tick();
        rel_ctx = 200; tick();
        rel_valid = 0; tick(); tick();
        alloc_req = 1; tick();
        alloc_req = 0; tick();

        // R3: exhaust the pool, stall, then recover after a release
        phase = "R3";
        alloc_req = 1;
        for (int k = 0; k < 300 && lowest_free() >= 0; k++) tick();
        repeat (4) tick();
        rel_valid = 1; rel_ctx = 77; tick();
        rel_valid = 0;
        tick();
        tick();
        alloc_req = 0;
        tick();

        // R8 / R10: hold and release of the bus
        phase = "R8";
        ni_ctx = 8'd5; ni_off = 4'd3; cc_ctx = 8'd255; cc_off = 4'd15;
        ni_bus_req = 1; repeat (4) tick();
        ni_off = 4'd9; tick();
        ni_bus_req = 0; tick(); tick();
        phase = "R10";
        cc_bus_req = 1; repeat (3) tick();
        cc_bus_req = 0; tick(); tick();

        // R9: contention alternates
        phase = "R9";
        ni_bus_req = 1; cc_bus_req = 1; tick(); tick();
        ni_bus_req = 0; tick(); tick();
        cc_bus_req = 0; tick();
        ni_bus_req = 1; cc_bus_req = 1; tick(); tick();
        ni_bus_req = 0; cc_bus_req = 0; tick(); tick();
        ni_bus_req = 1; cc_bus_req = 1; tick(); tick();
        cc_bus_req = 0; ni_bus_req = 0; tick();

        // mixed traffic
        phase = "mix";
        for (int k = 0; k < 3000; k++) begin
            idle();
            alloc_req    = ($urandom % 3) == 0;
            rel_valid    = ($urandom % 3) == 0;
            rel_ctx      = 8'($urandom % 24);
            disp_ready   = ($urandom % 2) == 0;
            if (rq.size() < 240) begin
                commit_valid = ($urandom % 3) == 0;
                commit_ctx   = 8'($urandom % 24);
                susp_valid   = ($urandom % 4) == 0;
                susp_ctx     = 8'($urandom % 16);
                resume_valid = ($urandom % 3) == 0;
                resume_ctx   = 8'($urandom % 16);
            end
            ni_bus_req = ($urandom % 4) != 0;
            cc_bus_req = ($urandom % 4) != 0;
            ni_ctx = 8'($urandom); ni_off = 4'($urandom);
            cc_ctx = 8'($urandom); cc_off = 4'($urandom);
            tick();
        end
        idle();
        tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule